// File: doc/BRIEF.md
# SDRAM Mode-Register Programming Sequencer

This block sits between a CPU-side bus slave port and the command/address pins of up to two SDRAM chip-select areas. Software programs an SDRAM mode register by making a dummy byte write into a reserved 4 KB window that belongs to the target area. The block does not use the write data. The low address bits of that write carry the mode value. The block answers by driving a precharge-all command, then a fixed number of idle cycles, then a mode-register-set command, then a further fixed wait. Only after that does it acknowledge the bus.

The mode fields sit at a different alignment in the bus address for a 32-bit SDRAM data bus and for a 16-bit one. A static width input selects which alignment applies. The block re-aligns the offset so that the mode fields land on SDRAM address pins 0 upward. A window write that is not byte-sized, or that carries a CAS latency code outside 1 to 3, is still acknowledged. It is flagged as an error and produces no SDRAM command.

Top module: `sdram_mrs_seq`

## Requirements
- R1: The block claims a bus write (`bus_req`=1, `bus_we`=1) only when address bits 31..12 equal 0xFFFFD or 0xFFFFE. 0xFFFFD selects the first area, which drives `sd_cs_n[0]`. 0xFFFFE selects the second area, which drives `sd_cs_n[1]`.
- R2: A legal claimed write (`bus_size`=00 for byte, CAS latency code 1..3) is accepted at a clock edge. In the cycle after that edge the block drives precharge-all. The addressed chip select is low, {ras_n,cas_n,we_n}=010, `sd_addr` bit 10 is 1 and every other `sd_addr` bit is 0.
- R3: Exactly TRP_CYC cycles follow the precharge-all. In each of them the addressed chip select is low, {ras_n,cas_n,we_n}=111 and `sd_addr`=0. The mode-register-set cycle comes right after them.
- R4: In the mode-register-set cycle the addressed chip select is low and {ras_n,cas_n,we_n}=000. `sd_addr` carries offset bits 11..2 on pins 9..0 when `bus_narrow`=0 (32-bit SDRAM bus), or offset bits 11..1 on pins 10..0 when `bus_narrow`=1 (16-bit SDRAM bus). All higher pins are 0. The CAS latency code is `sd_addr` bits 6..4.
- R5: TMRD_CYC idle cycles follow the mode-register-set cycle, driven as in R3. In the next cycle `bus_ack` is 1 for one cycle, `bus_err` is 0, and every chip select is high.
- R6: `bus_wait` is 1 while a claimed write is pending and not yet acknowledged. It is 0 in the acknowledge cycle.
- R7: A claimed write whose `bus_size` is not 00 (01 for 16-bit, 10 for 32-bit, 11 reserved) is acknowledged in the cycle after acceptance with `bus_err`=1. No chip select goes low.
- R8: A claimed byte write whose CAS latency code is 0 or 4..7 is handled as in R7.
- R9: During a sequence, only the chip select of the addressed area is low, and it stays low without a gap until the acknowledge cycle.
- R10: While reset is held, and after it is released, all chip selects and {ras_n,cas_n,we_n} are high, `sd_addr`=0, and `bus_ack`=`bus_err`=0.
- R11: A read into a window, or a write outside both windows, is ignored. It produces no acknowledge, no wait and no chip select.
- R12: After an acknowledge the block returns to idle with everything deselected, and it accepts the next window write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Bus access request, held until acknowledge |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size: 00 byte, 01 16-bit, 10 32-bit |
| bus_addr | input | 32 | Bus byte address |
| bus_narrow | input | 1 | SDRAM data bus width: 0 = 32-bit, 1 = 16-bit |
| bus_wait | output | 1 | Stall for a claimed, pending write |
| bus_ack | output | 1 | One-cycle completion strobe |
| bus_err | output | 1 | Rejected write, valid with `bus_ack` |
| sd_cs_n | output | 2 | Active-low chip select, one per area |
| sd_ras_n | output | 1 | Active-low row strobe |
| sd_cas_n | output | 1 | Active-low column strobe |
| sd_we_n | output | 1 | Active-low write enable |
| sd_addr | output | SDRAM_AW | SDRAM address pins |

## Verification
Each state of the controller drives its own command code and chip-select pattern on registered outputs. A wrong state or a wrong count therefore shows on the SDRAM pins in the very next cycle. The symptom is a missing or misplaced precharge-all, a mode-register-set one cycle early or late, or a chip select that drops out mid-sequence. A wrongly latched area or mode value shows as a bad `sd_addr` or the wrong `sd_cs_n` bit in the mode-register-set cycle. An illegal write that is wrongly treated as legal shows one cycle after acceptance: the acknowledge is missing and a command appears instead.

// File: rtl/sdram_mrs_pkg.sv
package sdram_mrs_pkg;

    // Controller states
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_TRP  = 2'd1,
        S_TMRD = 2'd2,
        S_ACK  = 2'd3
    } mrs_state_e;

    // {ras_n, cas_n, we_n}
    localparam logic [2:0] CMD_NOP  = 3'b111;
    localparam logic [2:0] CMD_PALL = 3'b010;
    localparam logic [2:0] CMD_MRS  = 3'b000;

    // Bus access size codes
    localparam logic [1:0] SZ_BYTE = 2'b00;

    // Address pin that selects "all banks" on precharge
    localparam int PALL_PIN = 10;

    // Position of the CAS latency code in the re-aligned mode word
    localparam int CL_LSB = 4;

endpackage

// File: rtl/sdram_mrs_decode.sv
module sdram_mrs_decode
    import sdram_mrs_pkg::*;
#(
    parameter int BUS_AW   = 32,
    parameter int OFF_W    = 12,
    parameter int N_AREA   = 2,
    parameter int SDRAM_AW = 14,
    parameter logic [N_AREA*(BUS_AW-OFF_W)-1:0] WIN_TAGS = 40'hFFFFE_FFFFD
) (
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic [1:0]          bus_size,
    input  logic [BUS_AW-1:0]   bus_addr,
    input  logic                bus_narrow,
    output logic                hit,
    output logic [N_AREA-1:0]   area_sel,
    output logic [SDRAM_AW-1:0] mode,
    output logic                legal
);
    localparam int TAG_W = BUS_AW - OFF_W;

    logic [N_AREA-1:0] match;
    logic [OFF_W-1:0]  offset;
    logic [OFF_W-1:0]  aligned;
    logic [2:0]        cl_code;

    for (genvar a = 0; a < N_AREA; a++) begin : g_win
        assign match[a] = (bus_addr[BUS_AW-1:OFF_W] == WIN_TAGS[a*TAG_W +: TAG_W]);
    end

    assign offset   = bus_addr[OFF_W-1:0];
    // 16-bit bus: fields one bit lower than on a 32-bit bus
    assign aligned  = bus_narrow ? (offset >> 1) : (offset >> 2);
    assign mode     = SDRAM_AW'(aligned);
    assign cl_code  = mode[CL_LSB +: 3];

    assign hit      = bus_req && bus_we && (|match);
    assign area_sel = match;
    assign legal    = (bus_size == SZ_BYTE) && (cl_code >= 3'd1) && (cl_code <= 3'd3);

endmodule

// File: rtl/sdram_mrs_ctrl.sv
module sdram_mrs_ctrl
    import sdram_mrs_pkg::*;
#(
    parameter int N_AREA   = 2,
    parameter int SDRAM_AW = 14,
    parameter int TRP_CYC  = 2,
    parameter int TMRD_CYC = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hit,
    input  logic [N_AREA-1:0]   area_sel,
    input  logic [SDRAM_AW-1:0] mode,
    input  logic                legal,
    output logic                bus_wait,
    output logic                bus_ack,
    output logic                bus_err,
    output logic [N_AREA-1:0]   sd_cs_n,
    output logic                sd_ras_n,
    output logic                sd_cas_n,
    output logic                sd_we_n,
    output logic [SDRAM_AW-1:0] sd_addr
);
    localparam int CMAX  = (TRP_CYC > TMRD_CYC) ? TRP_CYC : TMRD_CYC;
    localparam int CNT_W = $clog2(CMAX + 1) > 0 ? $clog2(CMAX + 1) : 1;
    localparam logic [SDRAM_AW-1:0] PALL_ADDR = SDRAM_AW'(1) << PALL_PIN;
    localparam logic [N_AREA-1:0]   CS_OFF    = '1;

    typedef struct packed {
        mrs_state_e          state;
        logic [CNT_W-1:0]    cnt;
        logic [N_AREA-1:0]   sel;
        logic [SDRAM_AW-1:0] mode;
        logic [N_AREA-1:0]   cs_n;
        logic [2:0]          cmd;
        logic [SDRAM_AW-1:0] addr;
        logic                ack;
        logic                err;
    } ctrl_t;

    ctrl_t d, q;

    always_comb begin
        d     = q;
        d.ack = 1'b0;
        d.err = 1'b0;
        unique case (q.state)
            S_IDLE: begin
                d.cs_n = CS_OFF;
                d.cmd  = CMD_NOP;
                d.addr = '0;
                if (hit) begin
                    if (legal) begin
                        d.state = S_TRP;
                        d.cnt   = CNT_W'(TRP_CYC);
                        d.sel   = area_sel;
                        d.mode  = mode;
                        d.cs_n  = ~area_sel;
                        d.cmd   = CMD_PALL;
                        d.addr  = PALL_ADDR;
                    end else begin
                        d.state = S_ACK;
                        d.ack   = 1'b1;
                        d.err   = 1'b1;
                    end
                end
            end
            S_TRP: begin
                if (q.cnt == '0) begin
                    d.state = S_TMRD;
                    d.cnt   = CNT_W'(TMRD_CYC);
                    d.cmd   = CMD_MRS;
                    d.addr  = q.mode;
                end else begin
                    d.cnt  = q.cnt - 1'b1;
                    d.cmd  = CMD_NOP;
                    d.addr = '0;
                end
            end
            S_TMRD: begin
                d.cmd  = CMD_NOP;
                d.addr = '0;
                if (q.cnt == '0) begin
                    d.state = S_ACK;
                    d.cs_n  = CS_OFF;
                    d.ack   = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: begin
                d.state = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= S_IDLE;
            q.cnt   <= '0;
            q.sel   <= '0;
            q.mode  <= '0;
            q.cs_n  <= CS_OFF;
            q.cmd   <= CMD_NOP;
            q.addr  <= '0;
            q.ack   <= 1'b0;
            q.err   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign bus_wait = hit && !q.ack;
    assign bus_ack  = q.ack;
    assign bus_err  = q.err;
    assign sd_cs_n  = q.cs_n;
    assign {sd_ras_n, sd_cas_n, sd_we_n} = q.cmd;
    assign sd_addr  = q.addr;

    assert_one_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~sd_cs_n));

    assert_cs_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state == S_TRP || q.state == S_TMRD) &&
         ($past(q.state) == S_TRP || $past(q.state) == S_TMRD)) |-> $stable(sd_cs_n));

    assert_err_with_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_ack);

    assert_ack_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    assert_idle_deselect_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_IDLE) |-> (sd_cs_n == CS_OFF && !bus_ack));

    assert_no_cmd_on_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> (sd_cs_n == CS_OFF));

endmodule

// File: rtl/sdram_mrs_seq.sv
module sdram_mrs_seq
    import sdram_mrs_pkg::*;
#(
    parameter int BUS_AW   = 32,
    parameter int OFF_W    = 12,
    parameter int N_AREA   = 2,
    parameter int SDRAM_AW = 14,
    parameter int TRP_CYC  = 2,
    parameter int TMRD_CYC = 2,
    parameter logic [N_AREA*(BUS_AW-OFF_W)-1:0] WIN_TAGS = 40'hFFFFE_FFFFD
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic [1:0]          bus_size,
    input  logic [BUS_AW-1:0]   bus_addr,
    input  logic                bus_narrow,
    output logic                bus_wait,
    output logic                bus_ack,
    output logic                bus_err,
    output logic [N_AREA-1:0]   sd_cs_n,
    output logic                sd_ras_n,
    output logic                sd_cas_n,
    output logic                sd_we_n,
    output logic [SDRAM_AW-1:0] sd_addr
);
    logic                hit;
    logic [N_AREA-1:0]   area_sel;
    logic [SDRAM_AW-1:0] mode;
    logic                legal;

    sdram_mrs_decode #(
        .BUS_AW   (BUS_AW),
        .OFF_W    (OFF_W),
        .N_AREA   (N_AREA),
        .SDRAM_AW (SDRAM_AW),
        .WIN_TAGS (WIN_TAGS)
    ) u_decode (
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_size   (bus_size),
        .bus_addr   (bus_addr),
        .bus_narrow (bus_narrow),
        .hit        (hit),
        .area_sel   (area_sel),
        .mode       (mode),
        .legal      (legal)
    );

    sdram_mrs_ctrl #(
        .N_AREA   (N_AREA),
        .SDRAM_AW (SDRAM_AW),
        .TRP_CYC  (TRP_CYC),
        .TMRD_CYC (TMRD_CYC)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .area_sel (area_sel),
        .mode     (mode),
        .legal    (legal),
        .bus_wait (bus_wait),
        .bus_ack  (bus_ack),
        .bus_err  (bus_err),
        .sd_cs_n  (sd_cs_n),
        .sd_ras_n (sd_ras_n),
        .sd_cas_n (sd_cas_n),
        .sd_we_n  (sd_we_n),
        .sd_addr  (sd_addr)
    );

endmodule

// File: tb/sdram_mrs_seq_test.sv
module sdram_mrs_seq_test;
    localparam int TRP  = 2;
    localparam int TMRD = 2;
    localparam int AW   = 14;
    localparam int NV   = 11;

    // {narrow, area, size[1:0], offset[11:0], legal}
    localparam logic [16:0] VEC [NV] = '{
        {1'b0, 1'b0, 2'b00, 12'h840, 1'b1},  // 32-bit, area A, CL1
        {1'b0, 1'b0, 2'b00, 12'h880, 1'b1},  // 32-bit, area A, CL2
        {1'b0, 1'b1, 2'b00, 12'h8C0, 1'b1},  // 32-bit, area B, CL3
        {1'b1, 1'b1, 2'b00, 12'h420, 1'b1},  // 16-bit, area B, CL1
        {1'b1, 1'b0, 2'b00, 12'h440, 1'b1},  // 16-bit, area A, CL2
        {1'b1, 1'b1, 2'b00, 12'h460, 1'b1},  // 16-bit, area B, CL3
        {1'b0, 1'b0, 2'b01, 12'h880, 1'b0},  // 16-bit access size
        {1'b0, 1'b1, 2'b10, 12'h840, 1'b0},  // 32-bit access size
        {1'b0, 1'b0, 2'b00, 12'h800, 1'b0},  // CL code 0
        {1'b1, 1'b1, 2'b00, 12'h480, 1'b0},  // CL code 4 on 16-bit bus
        {1'b0, 1'b0, 2'b00, 12'h9C0, 1'b0}   // CL code 7
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req = 1'b0;
    logic          bus_we = 1'b0;
    logic [1:0]    bus_size = 2'b00;
    logic [31:0]   bus_addr = 32'h0;
    logic          bus_narrow = 1'b0;
    logic          bus_wait, bus_ack, bus_err;
    logic [1:0]    sd_cs_n;
    logic          sd_ras_n, sd_cas_n, sd_we_n;
    logic [AW-1:0] sd_addr;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    sdram_mrs_seq #(
        .SDRAM_AW (AW),
        .TRP_CYC  (TRP),
        .TMRD_CYC (TMRD)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_size   (bus_size),
        .bus_addr   (bus_addr),
        .bus_narrow (bus_narrow),
        .bus_wait   (bus_wait),
        .bus_ack    (bus_ack),
        .bus_err    (bus_err),
        .sd_cs_n    (sd_cs_n),
        .sd_ras_n   (sd_ras_n),
        .sd_cas_n   (sd_cas_n),
        .sd_we_n    (sd_we_n),
        .sd_addr    (sd_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pins();
        return 32'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_addr});
    endfunction

    function automatic logic [31:0] exp_pins(input logic [1:0] cs, input logic [2:0] cmd,
                                             input logic [AW-1:0] a);
        return 32'({cs, cmd, a});
    endfunction

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic run_vec(input logic [16:0] v);
        logic          nar   = v[16];
        logic          area  = v[15];
        logic [1:0]    sz    = v[14:13];
        logic [11:0]   off   = v[12:1];
        logic          ok    = v[0];
        logic [1:0]    cs    = area ? 2'b01 : 2'b10;
        logic [AW-1:0] mval  = AW'(nar ? (off >> 1) : (off >> 2));
        @(negedge clk);
        bus_req    = 1'b1;
        bus_we     = 1'b1;
        bus_size   = sz;
        bus_narrow = nar;
        bus_addr   = (area ? 32'hFFFFE000 : 32'hFFFFD000) | 32'(off);
        #1 chk("R6 wait on claim", 32'(bus_wait), 32'd1);
        @(negedge clk);
        if (ok) begin
            // R1 R2 R9: precharge-all on the addressed area only
            chk("R2 R1 R9 precharge-all", pins(), exp_pins(cs, 3'b010, AW'(1) << 10));
            chk("R6 wait held", 32'(bus_wait), 32'd1);
            for (int i = 0; i < TRP; i++) begin
                @(negedge clk);
                chk("R3 trp idle", pins(), exp_pins(cs, 3'b111, '0));
            end
            @(negedge clk);
            chk("R4 mode-register-set", pins(), exp_pins(cs, 3'b000, mval));
            chk("R6 wait held", 32'(bus_wait), 32'd1);
            for (int i = 0; i < TMRD; i++) begin
                @(negedge clk);
                chk("R5 tmrd idle", pins(), exp_pins(cs, 3'b111, '0));
                chk("R5 no early ack", 32'(bus_ack), 32'd0);
            end
            @(negedge clk);
            chk("R5 ack", 32'({bus_ack, bus_err}), 32'b10);
        end else begin
            chk("R7 R8 error ack", 32'({bus_ack, bus_err}), 32'b11);
        end
        chk("R6 wait released", 32'(bus_wait), 32'd0);
        chk("R5 R7 R8 deselect on ack", pins(), exp_pins(2'b11, 3'b111, '0));
        bus_req = 1'b0;
        bus_we  = 1'b0;
        @(negedge clk);
        chk("R12 idle after ack", 32'({bus_ack, sd_cs_n}), 32'b011);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        // R10: reset state while held and after release
        repeat (3) @(negedge clk);
        chk("R10 reset pins", pins(), exp_pins(2'b11, 3'b111, '0));
        chk("R10 reset ack/err", 32'({bus_ack, bus_err}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 after release", pins(), exp_pins(2'b11, 3'b111, '0));

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R11: read into window is ignored
        @(negedge clk);
        bus_req  = 1'b1;
        bus_we   = 1'b0;
        bus_size = 2'b00;
        bus_addr = 32'hFFFFD880;
        #1 chk("R11 read wait", 32'(bus_wait), 32'd0);
        repeat (3) begin
            @(negedge clk);
            chk("R11 read ignored", 32'({bus_ack, sd_cs_n, sd_ras_n}), 32'b0111);
        end
        // R11: write just below the first window is ignored
        bus_we   = 1'b1;
        bus_addr = 32'hFFFFC880;
        #1 chk("R11 outside wait", 32'(bus_wait), 32'd0);
        repeat (3) begin
            @(negedge clk);
            chk("R11 outside ignored", 32'({bus_ack, sd_cs_n, sd_ras_n}), 32'b0111);
        end
        bus_req = 1'b0;
        bus_we  = 1'b0;

        // R12: a legal sequence still runs after the ignored traffic
        run_vec({1'b0, 1'b1, 2'b00, 12'h880, 1'b1});
        report();
    end

endmodule